// File: doc/BRIEF.md
# Dual-Slope Converter Sequencer

This block is the digital control section of a three-and-a-half digit dual-slope integrating converter. A prescaler divides the input clock by four to form count ticks. A phase controller uses those ticks to run a measurement cycle of constant length. The cycle moves through three phases in order: signal integrate, then reference deintegrate, then auto-zero. Each phase has its own one-hot enable output, which goes to the analog switch drivers outside the block.

During deintegrate, a chain of BCD decade counters counts ticks. The chain has units, tens and hundreds digits plus a thousands half-digit. Counting stops on the first tick after the comparator, passed through a two-flop synchronizer, reports the zero crossing. The final count goes into a display latch. Each latched digit has its own seven-segment decoder.

Auto-zero takes whatever part of the deintegrate budget was not used, so every cycle has the same length whatever the input. The hold input freezes the latch while measurements keep running.

Top module: `dsq_sequencer`

## Requirements
- R1: After synchronous reset, the auto-zero enable is high and the other two enables are low. The overrange flag is low. The units, tens and hundreds outputs show "0" and the thousands output is blank. This first auto-zero lasts 1000 counts (4000 clocks).
- R2: Exactly one of the three phase enables is high in every clock cycle.
- R3: The signal-integrate phase lasts exactly 1000 counts (4000 clocks), and phase changes happen only on count ticks. Conversions keep running while hold is high.
- R4: The comparator goes through a two-flop synchronizer. Deintegrate ends on the first tick at which the synchronized comparator is high. The latched reading is the number of ticks counted before that tick, in BCD, with each digit kept in the range 0 to 9.
- R5: The time from one integrate start to the next is always 4000 counts (16000 clocks), whatever the reading.
- R6: Auto-zero starts at the tick that ends deintegrate and lasts for the remaining counts of the cycle.
- R7: If the synchronized comparator is never high during deintegrate, the phase ends after 2000 ticks (8000 clocks). The overrange flag is then set and all four digit outputs go blank.
- R8: While hold is high at the tick that ends deintegrate, the digit outputs and the overrange flag keep their previous values. The next conversion taken with hold low updates them.
- R9: Segment outputs are active high with bit order {g,f,e,d,c,b,a}. Digits 0 to 9 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex). The thousands output shows 06 for readings of 1000 or more and 00 otherwise. Blank means 00.
- R10: A valid reading latched with hold low clears the overrange flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| comp_in | input | 1 | Asynchronous comparator zero-crossing indication |
| hold_in | input | 1 | High freezes the display latch |
| ph_int | output | 1 | Signal-integrate enable |
| ph_deint | output | 1 | Reference-deintegrate enable |
| ph_az | output | 1 | Auto-zero enable |
| seg_units | output | 7 | Units digit segments |
| seg_tens | output | 7 | Tens digit segments |
| seg_hunds | output | 7 | Hundreds digit segments |
| seg_thou | output | 7 | Thousands half-digit segments |
| over_flag | output | 1 | Latched overrange indication |

## Verification
A position counter that has drifted shows up within one cycle as a wrong integrate length or a wrong integrate-to-integrate period. A slip of even one tick is measured exactly in clocks. A fault in a decade carry or in the synchronizer latency changes the deintegrate length and the latched digits at the end of that same deintegrate. The bench compares both against a tick formula worked out from the comparator timing. A hold or overrange latch fault shows on the segment outputs at the first conversion after the triggering condition.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
    localparam int NDEC      = 3;
    localparam int SEG_W     = 7;
    localparam int DEINT_MAX = 2 * (10 ** NDEC);

    typedef enum logic [1:0] {
        PH_AZ    = 2'd0,
        PH_INT   = 2'd1,
        PH_DEINT = 2'd2
    } phase_e;

    typedef logic [3:0] bcd_t;

    typedef struct packed {
        logic              over;
        logic              half;
        bcd_t [NDEC-1:0]   dig;
    } reading_t;

    function automatic logic [SEG_W-1:0] seg_of(input bcd_t d, input logic blank);
        logic [SEG_W-1:0] s;
        case (d)
            4'd0: s = 7'h3F;
            4'd1: s = 7'h06;
            4'd2: s = 7'h5B;
            4'd3: s = 7'h4F;
            4'd4: s = 7'h66;
            4'd5: s = 7'h6D;
            4'd6: s = 7'h7D;
            4'd7: s = 7'h07;
            4'd8: s = 7'h7F;
            4'd9: s = 7'h6F;
            default: s = 7'h00;
        endcase
        return blank ? '0 : s;
    endfunction
endpackage

// File: rtl/dsq_prescale.sv
module dsq_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    logic [DW-1:0] div_q;

    assign tick = (div_q == DW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst)       div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/dsq_bcd_chain.sv
module dsq_bcd_chain
    import dsq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            inc,
    output bcd_t [NDEC-1:0] dig,
    output logic            half,
    output logic            at_max
);
    logic [NDEC:0] carry;
    logic [NDEC-1:0] nine;

    assign carry[0] = inc;

    genvar i;
    generate
        for (i = 0; i < NDEC; i++) begin : g_dec
            assign nine[i]       = (dig[i] == 4'd9);
            assign carry[i+1]    = carry[i] & nine[i];
            always_ff @(posedge clk) begin
                if (rst || clr)    dig[i] <= 4'd0;
                else if (carry[i]) dig[i] <= nine[i] ? 4'd0 : dig[i] + 4'd1;
            end
            // R4
            digit_range_chk: assert property (@(posedge clk) disable iff (rst)
                dig[i] <= 4'd9);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr) half <= 1'b0;
        else            half <= half ^ carry[NDEC];
    end

    assign at_max = half & (&nine);
endmodule

// File: rtl/dsq_phase_ctrl.sv
module dsq_phase_ctrl
    import dsq_pkg::*;
#(
    parameter int INT_COUNTS    = 1000,
    parameter int AZ_MIN_COUNTS = 1000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   comp_s,
    input  logic   cnt_max,
    output phase_e phase,
    output logic   cnt_clr,
    output logic   cnt_inc,
    output logic   done,
    output logic   over_det
);
    localparam int CYCLE     = INT_COUNTS + DEINT_MAX + AZ_MIN_COUNTS;
    localparam int PW        = $clog2(CYCLE);
    localparam int START_POS = INT_COUNTS + DEINT_MAX;

    logic [PW-1:0] pos;
    logic          wrap;
    logic          int_end;

    assign wrap    = (pos == PW'(CYCLE - 1));
    assign int_end = (phase == PH_INT) && (pos == PW'(INT_COUNTS - 1));
    assign cnt_clr = tick && int_end;
    assign done    = tick && (phase == PH_DEINT) && (comp_s || cnt_max);
    assign over_det = done && !comp_s;
    assign cnt_inc = tick && (phase == PH_DEINT) && !comp_s && !cnt_max;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_AZ;
            pos   <= PW'(START_POS);
        end else if (tick) begin
            pos <= wrap ? '0 : pos + 1'b1;
            unique case (phase)
                PH_AZ:    if (wrap) phase <= PH_INT;
                PH_INT:   if (int_end) phase <= PH_DEINT;
                PH_DEINT: if (comp_s || cnt_max) phase <= PH_AZ;
                default:  phase <= PH_AZ;
            endcase
        end
    end

    // R3
    phase_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(phase));
    // R3
    deint_from_int_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DEINT) && !$stable(phase) |-> $past(phase) == PH_INT);
    // R4
    deint_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DEINT) && tick && !comp_s && !cnt_max |=> phase == PH_DEINT);
endmodule

// File: rtl/dsq_sequencer.sv
module dsq_sequencer
    import dsq_pkg::*;
#(
    parameter int CLK_DIV       = 4,
    parameter int INT_COUNTS    = 1000,
    parameter int AZ_MIN_COUNTS = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             comp_in,
    input  logic             hold_in,
    output logic             ph_int,
    output logic             ph_deint,
    output logic             ph_az,
    output logic [SEG_W-1:0] seg_units,
    output logic [SEG_W-1:0] seg_tens,
    output logic [SEG_W-1:0] seg_hunds,
    output logic [SEG_W-1:0] seg_thou,
    output logic             over_flag
);
    logic            tick;
    logic [1:0]      sync_q;
    logic            comp_s;
    phase_e          phase;
    logic            cnt_clr, cnt_inc, done, over_det, cnt_max;
    bcd_t [NDEC-1:0] cnt_dig;
    logic            cnt_half;
    reading_t        lat;
    logic [SEG_W-1:0] dig_seg [NDEC];

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[0], comp_in};
    end
    assign comp_s = sync_q[1];

    dsq_prescale #(.DIV(CLK_DIV)) u_pre (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    dsq_phase_ctrl #(
        .INT_COUNTS   (INT_COUNTS),
        .AZ_MIN_COUNTS(AZ_MIN_COUNTS)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .comp_s  (comp_s),
        .cnt_max (cnt_max),
        .phase   (phase),
        .cnt_clr (cnt_clr),
        .cnt_inc (cnt_inc),
        .done    (done),
        .over_det(over_det)
    );

    dsq_bcd_chain u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .dig   (cnt_dig),
        .half  (cnt_half),
        .at_max(cnt_max)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lat <= '0;
        end else if (done && !hold_in) begin
            lat.over <= over_det;
            lat.half <= cnt_half;
            lat.dig  <= cnt_dig;
        end
    end

    genvar i;
    generate
        for (i = 0; i < NDEC; i++) begin : g_seg
            assign dig_seg[i] = seg_of(lat.dig[i], lat.over);
        end
    endgenerate

    assign seg_units = dig_seg[0];
    assign seg_tens  = dig_seg[1];
    assign seg_hunds = dig_seg[2];
    assign seg_thou  = (lat.half && !lat.over) ? 7'h06 : 7'h00;
    assign over_flag = lat.over;

    assign ph_int   = (phase == PH_INT);
    assign ph_deint = (phase == PH_DEINT);
    assign ph_az    = (phase == PH_AZ);

    // R2
    phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({ph_int, ph_deint, ph_az}) == 1);
    // R8
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        hold_in |=> $stable(lat));
    // R6
    az_after_deint_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> ph_az);
endmodule

// File: tb/dsq_sequencer_tb.sv
module dsq_sequencer_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       comp_in = 1'b0;
    logic       hold_in = 1'b0;
    logic       ph_int, ph_deint, ph_az, over_flag;
    logic [6:0] seg_units, seg_tens, seg_hunds, seg_thou;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    int onehot_bad = 0;
    int prev_start = 0;
    bit have_prev = 0;
    bit finished = 0;
    logic [28:0] snap;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dsq_sequencer dut_i (
        .clk(clk), .rst(rst), .comp_in(comp_in), .hold_in(hold_in),
        .ph_int(ph_int), .ph_deint(ph_deint), .ph_az(ph_az),
        .seg_units(seg_units), .seg_tens(seg_tens), .seg_hunds(seg_hunds),
        .seg_thou(seg_thou), .over_flag(over_flag)
    );

    always @(negedge clk)
        if (!rst && (int'(ph_int) + int'(ph_deint) + int'(ph_az)) != 1)
            onehot_bad++;

    function automatic logic [6:0] exp_seg(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [28:0] disp_now();
        return {over_flag, seg_thou, seg_hunds, seg_tens, seg_units};
    endfunction

    task automatic do_conv(input int t_delay, input bit hold_v);
        int t0, t1, t2, j, res, len;
        bit ovr;
        logic [28:0] expd;
        hold_in = hold_v;
        while (!ph_int) @(negedge clk);
        t0 = cyc;
        if (have_prev) check(t0 - prev_start == 16000, "R5", "cycle clocks", t0 - prev_start, 16000);
        prev_start = t0;
        have_prev = 1;
        while (!ph_deint) @(negedge clk);
        t1 = cyc;
        check(t1 - t0 == 4000, "R3", "integrate clocks", t1 - t0, 4000);
        if (t_delay >= 0) begin
            repeat (t_delay) @(negedge clk);
            comp_in = 1'b1;
        end
        while (!ph_az) @(negedge clk);
        t2 = cyc;
        comp_in = 1'b0;
        ovr = 1'b1;
        res = 0;
        len = 8000;
        if (t_delay >= 0) begin
            j = (t_delay + 6) / 4;
            if (j <= 2000) begin
                ovr = 1'b0;
                res = j - 1;
                len = 4 * j;
            end
        end
        check(t2 - t1 == len, ovr ? "R7" : "R4", "deintegrate clocks", t2 - t1, len);
        if (hold_v) begin
            // R8: display frozen, still one-hot conversions above
            check(disp_now() == snap, "R8", "held display changed", int'(disp_now() & 29'hFFFFFFF), int'(snap & 29'hFFFFFFF));
            check(over_flag == snap[28], "R8", "held over flag", int'(over_flag), int'(snap[28]));
        end else if (ovr) begin
            expd = {1'b1, 28'h0};
            check(over_flag == 1'b1, "R7", "over flag", int'(over_flag), 1);
            check(disp_now() == expd, "R7", "blank digits", int'(disp_now() & 29'hFFFFFFF), 0);
        end else begin
            expd = {1'b0, (res >= 1000) ? 7'h06 : 7'h00, exp_seg((res / 100) % 10),
                    exp_seg((res / 10) % 10), exp_seg(res % 10)};
            check(over_flag == 1'b0, "R10", "over flag cleared", int'(over_flag), 0);
            check(disp_now() == expd, "R9", $sformatf("segments for %0d", res),
                  int'(disp_now()), int'(expd));
        end
        snap = disp_now();
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(ph_az && !ph_int && !ph_deint, "R1", "phases after reset",
              int'({ph_int, ph_deint, ph_az}), 1);
        check(over_flag == 1'b0, "R1", "over after reset", int'(over_flag), 0);
        check(seg_units == 7'h3F && seg_tens == 7'h3F && seg_hunds == 7'h3F, "R1",
              "zero digits", int'(seg_units), 'h3F);
        check(seg_thou == 7'h00, "R1", "thousands blank", int'(seg_thou), 0);
        while (!ph_int) @(negedge clk);
        // R1: first auto-zero is 1000 counts from reset release
        check(cyc >= 4000 && cyc <= 4008, "R1", "first auto-zero clocks", cyc, 4006);
        snap = disp_now();
        do_conv(0, 0);
        do_conv(4, 0);
        do_conv(7997, 0);
        do_conv(-1, 0);
        do_conv(int'($urandom_range(7900, 0)), 0);
        do_conv(int'($urandom_range(7900, 0)), 1);
        do_conv(-1, 1);
        do_conv(3996, 0);
        do_conv(4000, 0);
        do_conv(int'($urandom_range(7900, 0)), 0);
        // R2
        check(onehot_bad == 0, "R2", "non-one-hot cycles", onehot_bad, 0);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(posedge clk) begin
        if (cyc > WATCHDOG && !finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule